// File: doc/BRIEF.md
# Ready-Triggered Converter Result Reader

This block is an SPI master that fetches one conversion result from a multi-channel converter each time the converter signals that a result is ready. The converter holds a single result register that is overwritten by every new conversion. Each result must therefore be clocked out before the next ready strobe arrives. The block sends no command bytes: the converter shifts its result out as soon as chip select drops and SCLK starts. The block only drives SCLK and chip select and samples MISO.

A falling edge on the low-active ready input starts one frame. The frame is 24 bits long, or 32 bits when the status byte is enabled, in which case the status byte arrives first. At the end of the frame the result, the status byte and the channel number taken from it appear on the outputs with a one-cycle valid strobe. The consumer can compare successive channel numbers to spot skipped channels. A ready edge that arrives while a frame is still running means a result was lost. It raises a sticky overrun flag that only a clear input removes.

The SCLK rate is set by a divider ratio in system clocks, and it never goes faster than half the system clock.

Top module: `adc_frame_reader`

## Requirements
- R1: A falling edge on `rdy_n` that is seen while `cs_n` is high starts a frame. `rdy_n` passes through a two-flop synchroniser, so `cs_n` goes low on the third rising `clk` edge after `rdy_n` is first sampled low. No command bits are sent.
- R2: A frame has 24 SCLK periods when `stat_en` is 0 and 32 when it is 1. `stat_en` and `div_ratio` are sampled when the frame starts, and later changes do not affect the running frame.
- R3: One SCLK period is R system clocks, where R is `div_ratio` with any value below 2 replaced by 2. Each period is low for R minus floor(R/2) clocks and then high for floor(R/2) clocks. SCLK is low whenever `cs_n` is high (SPI mode 0).
- R4: MISO is sampled as SCLK rises, most significant bit first. With the status byte enabled, the first 8 bits go to `res_status` and the last 24 bits go to `res_data`. Without it, all 24 bits go to `res_data` and `res_status` is 0.
- R5: `res_chan` equals bits [4:0] of `res_status`, which hold the channel number.
- R6: `cs_n` stays low for exactly N×R clocks, where N is the frame length in bits. On the cycle it returns high, `res_valid` is high for exactly one clock. The result outputs then hold their values until the next frame completes.
- R7: A `rdy_n` falling edge seen while `cs_n` is low sets `overrun` on the next clock. It neither restarts nor alters the running frame.
- R8: `overrun` stays set until `ovr_clr` is high. If a new overrun and a clear occur in the same cycle, the set wins.
- R9: After reset, `cs_n` is 1 and `sclk`, `res_valid`, `overrun`, `res_data`, `res_status` and `res_chan` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rdy_n | input | 1 | Low-active result-ready strobe from the converter |
| miso | input | 1 | Serial data from the converter |
| div_ratio | input | DIV_W | System clocks per SCLK period (minimum 2 after clamping) |
| stat_en | input | 1 | Read the leading status byte as part of each frame |
| ovr_clr | input | 1 | Clears the overrun flag |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, low for the whole frame |
| res_data | output | DATA_W | Captured conversion result |
| res_status | output | STAT_W | Captured status byte, 0 when disabled |
| res_chan | output | CHAN_W | Channel number from the status byte |
| res_valid | output | 1 | One-cycle strobe marking a completed frame |
| overrun | output | 1 | Sticky flag for a ready strobe that arrived during a frame |

## Verification
`cs_n` is due low three rising edges after `rdy_n` is driven low. Each SCLK level change is due at a fixed offset of the period R within the frame. `res_valid` and the new result are due exactly N×R clocks after the frame starts. `overrun` is due one clock after the synchronised ready edge. The bench keeps a reference model that advances at every rising edge and computes each of these times from the stimulus with integer counters. It compares every output against the model on the falling edge, so each result is checked in the exact cycle it is due and in every cycle around it.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 24,
  parameter int STAT_W = 8,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_n,
  input  logic              miso,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              stat_en,
  input  logic              ovr_clr,
  output logic              sclk,
  output logic              cs_n,
  output logic [DATA_W-1:0] res_data,
  output logic [STAT_W-1:0] res_status,
  output logic [CHAN_W-1:0] res_chan,
  output logic              res_valid,
  output logic              overrun
);
  localparam int FULL_W = DATA_W + STAT_W;
  localparam int BIT_W  = $clog2(FULL_W + 1);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

  logic [2:0]        rdy_sync;
  logic              rdy_fall;
  logic              busy, sclk_q, stat_q;
  logic [DIV_W-1:0]  ratio_q, cnt, hi_len, lo_len, ratio_in;
  logic [BIT_W-1:0]  bits_left;
  logic [FULL_W-1:0] shreg;
  logic              phase_end;

  assign rdy_fall  = rdy_sync[2] & ~rdy_sync[1];
  assign ratio_in  = (div_ratio < TWO) ? TWO : div_ratio;
  assign hi_len    = ratio_q >> 1;
  assign lo_len    = ratio_q - hi_len;
  assign phase_end = sclk_q ? (cnt == hi_len - ONE) : (cnt == lo_len - ONE);
  assign sclk      = sclk_q;
  assign cs_n      = ~busy;
  assign res_chan  = res_status[CHAN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_sync   <= '1;
      busy       <= 1'b0;
      sclk_q     <= 1'b0;
      stat_q     <= 1'b0;
      ratio_q    <= TWO;
      cnt        <= '0;
      bits_left  <= '0;
      shreg      <= '0;
      res_data   <= '0;
      res_status <= '0;
      res_valid  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      rdy_sync  <= {rdy_sync[1:0], rdy_n};
      res_valid <= 1'b0;

      if (rdy_fall && busy)
        overrun <= 1'b1;
      else if (ovr_clr)
        overrun <= 1'b0;

      if (!busy) begin
        if (rdy_fall) begin
          busy      <= 1'b1;
          sclk_q    <= 1'b0;
          cnt       <= '0;
          bits_left <= stat_en ? BIT_W'(FULL_W) : BIT_W'(DATA_W);
          stat_q    <= stat_en;
          ratio_q   <= ratio_in;
          shreg     <= '0;
        end
      end else if (phase_end) begin
        cnt    <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          shreg <= {shreg[FULL_W-2:0], miso};
        end else if (bits_left == BIT_W'(1)) begin
          busy       <= 1'b0;
          res_valid  <= 1'b1;
          res_data   <= shreg[DATA_W-1:0];
          res_status <= stat_q ? shreg[FULL_W-1:DATA_W] : '0;
        end else begin
          bits_left <= bits_left - BIT_W'(1);
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

module adc_frame_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic res_valid,
  input logic overrun,
  input logic ovr_clr,
  input logic rdy_fall
);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_valid_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));
  p_end_gives_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> res_valid);
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_fall && !cs_n) |=> overrun);
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .res_valid(res_valid),
  .overrun(overrun), .ovr_clr(ovr_clr), .rdy_fall(rdy_fall)
);

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
  logic        clk = 0, rst_n = 0, rdy_n = 1, miso, stat_en = 0, ovr_clr = 0;
  logic [7:0]  div_ratio = 8'd4;
  logic        sclk, cs_n, res_valid, overrun;
  logic [23:0] res_data;
  logic [7:0]  res_status;
  logic [4:0]  res_chan;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_frame_reader u0 (
    .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .miso(miso), .div_ratio(div_ratio),
    .stat_en(stat_en), .ovr_clr(ovr_clr), .sclk(sclk), .cs_n(cs_n),
    .res_data(res_data), .res_status(res_status), .res_chan(res_chan),
    .res_valid(res_valid), .overrun(overrun));

  // converter model: shifts its word out MSB first, changing after SCLK falls
  logic [31:0] slave_word = 32'h0;
  logic [31:0] cur_word = 32'h0;
  int idx = -1;
  always @(negedge cs_n) begin cur_word = slave_word; idx = stat_en ? 31 : 23; end
  always @(negedge sclk) if (!cs_n) idx = idx - 1;
  assign miso = (!cs_n && idx >= 0) ? cur_word[idx] : 1'b0;

  int rises = 0;
  always @(posedge sclk) if (!cs_n) rises++;
  always @(negedge cs_n) rises = 0;

  // reference model
  int m1 = 1, m2 = 1, m3 = 1, t = 0, rr = 2, nb = 24;
  bit mbusy = 0, mov = 0, mvalid = 0, mstat = 0;
  logic [31:0] mword = 0;
  logic [23:0] edata = 0;
  logic [7:0]  estat = 0;
  always @(posedge clk) begin
    bit fall, wb;
    if (!rst_n) begin
      m1 = 1; m2 = 1; m3 = 1; mbusy = 0; mov = 0; mvalid = 0; edata = 0; estat = 0;
    end else begin
      fall = (m3 == 1 && m2 == 0);
      wb = mbusy;
      mvalid = 0;
      m3 = m2; m2 = m1; m1 = int'(rdy_n);
      if (wb) begin
        t++;
        if (t == nb * rr) begin
          mbusy = 0; mvalid = 1;
          edata = mword[23:0];
          estat = mstat ? mword[31:24] : 8'h0;
        end
      end
      if (fall && wb) mov = 1;
      else if (ovr_clr) mov = 0;
      if (fall && !wb) begin
        mbusy = 1; t = 0;
        rr = (div_ratio < 2) ? 2 : int'(div_ratio);
        mstat = stat_en; nb = stat_en ? 32 : 24; mword = slave_word;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit esclk;
    esclk = mbusy && ((t % rr) >= (rr - rr / 2));
    chk(cs_n == !mbusy, "R1/R6 cs_n", cs_n, !mbusy);
    chk(sclk == esclk, "R3 sclk", sclk, esclk);
    chk(res_valid == mvalid, "R6 res_valid", res_valid, mvalid);
    chk(overrun == mov, "R7/R8 overrun", overrun, mov);
    chk(res_data == edata, "R4 res_data", res_data, edata);
    chk(res_status == estat, "R4 res_status", res_status, estat);
    chk(res_chan == estat[4:0], "R5 res_chan", res_chan, estat[4:0]);
    if (res_valid) chk(rises == nb, "R2 sclk periods per frame", rises, nb);
  end

  task automatic pulse_ready(input int hold);
    @(negedge clk) rdy_n = 0;
    repeat (hold) @(negedge clk);
    rdy_n = 1;
  endtask

  task automatic frame(input logic [31:0] w, input bit st, input logic [7:0] dv);
    slave_word = w; stat_en = st; div_ratio = dv;
    pulse_ready(2);
    repeat (35 * ((dv < 2) ? 2 : dv) + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && res_valid == 0 && overrun == 0 &&
        res_data == 0 && res_status == 0 && res_chan == 0, "R9 reset state",
        {cs_n, sclk, res_valid, overrun}, 4'b1000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    frame(32'h00A5C3F1, 0, 8'd4);
    frame(32'h93123456, 1, 8'd5);
    frame(32'h8FFFFFFF, 1, 8'd0);   // R3 clamp of 0
    frame(32'h00000001, 0, 8'd1);   // R3 clamp of 1
    frame(32'h00800000, 0, 8'd3);
    // R2: stat_en and divider changes during a frame have no effect
    slave_word = 32'h84ABCDEF; stat_en = 1; div_ratio = 8'd2;
    pulse_ready(2);
    repeat (10) @(negedge clk);
    stat_en = 0; div_ratio = 8'd7;
    repeat (80) @(negedge clk);
    // R7: second ready edge mid-frame raises overrun, frame completes intact
    slave_word = 32'h11223344; stat_en = 1; div_ratio = 8'd2;
    pulse_ready(1);
    repeat (20) @(negedge clk);
    slave_word = 32'hDEADBEEF;
    pulse_ready(1);
    repeat (60) @(negedge clk);
    chk(overrun == 1, "R7 overrun after mid-frame ready", overrun, 1);
    // R8: flag survives another good frame, then clears
    frame(32'h82000055, 1, 8'd6);
    chk(overrun == 1, "R8 overrun sticky", overrun, 1);
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    chk(overrun == 0, "R8 overrun cleared", overrun, 0);
    frame(32'h7F000000, 0, 8'd9);
    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule